// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI shift engine from the module clock. It produces a level that toggles at a programmed rate with a 50% duty cycle. With that level it gives two single-cycle strobes, one in the cycle the level rises and one in the cycle it falls. The shift engine uses the strobes as clock enables for launching and capturing bits. Everything runs in the module clock domain.

One 13-bit clock-control word selects the rate. It offers two divide laws. The linear law divides by an even integer, 2·(n+1), where n is an 8-bit value. The exponential law divides by 2^(m+1), where m is a 4-bit exponent. A select bit chooses which law applies. The word may be written at any time. The divider copies it into a working copy at each transfer start, so a write never disturbs a transfer that is already in progress.

The divider runs only while the engine reports busy. It restarts its phase at every transfer start, so the first half-period of a transfer always has its full length.

Top module: `spi_sclk_div`

## Requirements
- R1: The control word has three fields. Bits [7:0] hold the linear value n. Bits [11:8] hold the exponent m. Bit 12 selects the law: 1 selects linear and 0 selects exponential. The field of the law that is not selected has no effect on the output.
- R2: In linear mode each half-period of `sck_o` lasts n+1 module-clock cycles, so the clock is the module clock divided by 2·(n+1).
- R3: In exponential mode each half-period of `sck_o` lasts 2^m module-clock cycles, so the clock is the module clock divided by 2^(m+1). This holds up to m = 15.
- R4: Linear mode with n = 0 gives the fastest output: `sck_o` toggles on every module-clock cycle.
- R5: After the clock edge that samples `xfer_start` high, `sck_o` is low. Its first rise comes exactly one full half-period (H cycles) later. Every later toggle follows the previous one by H cycles.
- R6: `sck_lead_o` is high for exactly the cycles in which `sck_o` has just risen. `sck_trail_o` is high for exactly the cycles in which `sck_o` has just fallen. The two strobes are never high together.
- R7: While `xfer_busy` is low, `sck_o`, `sck_lead_o` and `sck_trail_o` stay low, whatever is written to the control word.
- R8: A control-word write made during a transfer leaves the current transfer's rate unchanged. The new rate applies from the next `xfer_start`.
- R9: After reset, all three outputs are low.
- R10: If `xfer_busy` drops while `sck_o` is high, `sck_o` returns low at the next edge and no trailing strobe is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 13 | Control word: n in [7:0], m in [11:8], law select in [12] |
| xfer_start | input | 1 | One-cycle pulse at the start of a transfer |
| xfer_busy | input | 1 | High while the shift engine is transferring |
| sck_o | output | 1 | Divided serial clock level, idle low |
| sck_lead_o | output | 1 | One-cycle strobe marking a rise of `sck_o` |
| sck_trail_o | output | 1 | One-cycle strobe marking a fall of `sck_o` |

## Verification
A wrong half-period terminal count or a bad working copy shows as a misplaced toggle. It is visible at the first rise after the start, which happens H cycles after the start edge. It then repeats in every later half-period. A phase counter that fails to clear shows as a short first half-period. A toggle flop that misbehaves gives a strobe whose polarity does not match the new level of `sck_o`. Each of these faults appears within one or two half-periods of the transfer start, so the bench checks all three outputs on every cycle of each transfer.

// File: rtl/spi_sclk_div_pkg.sv
// Shared types for the SPI serial clock divider.
// Assumes the control word places the linear value lowest, then the exponent,
// then the law select bit, with field widths taken from the top's parameters.
package spi_sclk_div_pkg;

    typedef enum logic {
        DIV_EXP = 1'b0,
        DIV_LIN = 1'b1
    } div_law_e;

endpackage

// File: rtl/spi_sclk_div_cfg.sv
// Control word register plus the working terminal count.
// The terminal count (half-period minus one) is computed from the stored word
// and copied only on a transfer start, so writes never affect a live transfer.
module spi_sclk_div_cfg
    import spi_sclk_div_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 15,
    localparam int REG_W = LIN_W + EXP_W + 1,
    localparam int SEL_B = LIN_W + EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             xfer_start,
    output logic [CNT_W-1:0] tc_o
);

    logic [REG_W-1:0] word_q;
    logic [LIN_W-1:0] lin_n;
    logic [EXP_W-1:0] exp_m;
    div_law_e         law;
    logic [CNT_W-1:0] tc_next;
    logic [CNT_W-1:0] tc_q;

    // Holds the programmed control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (cfg_we) word_q <= cfg_wdata;
    end

    // Splits the word into its fields.
    always_comb begin
        lin_n = word_q[LIN_W-1:0];
        exp_m = word_q[SEL_B-1:LIN_W];
        law   = div_law_e'(word_q[SEL_B]);
    end

    // Terminal count: n for linear, 2^m - 1 for exponential (wraps to all ones at top).
    always_comb begin
        if (law == DIV_LIN) tc_next = CNT_W'(lin_n);
        else                tc_next = (CNT_W'(1) << exp_m) - CNT_W'(1);
    end

    // Working terminal count, loaded only at a transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n)          tc_q <= '0;
        else if (xfer_start) tc_q <= tc_next;
    end

    assign tc_o = tc_q;

    assert_tc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |=> $stable(tc_q));

endmodule

// File: rtl/spi_sclk_div_count.sv
// Half-period phase counter.
// Counts module-clock cycles up to the terminal count and pulses tick_o at it.
// Assumes tc_i only changes on a cycle where clear_i is high.
module spi_sclk_div_count #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] tc_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = !clear_i && (cnt_q == tc_i);

    // Advances the phase, wrapping at the terminal count, held at zero when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (tick_o)       cnt_q <= '0;
        else                   cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (cnt_q <= tc_i));

endmodule

// File: rtl/spi_sclk_div_toggle.sv
// Serial clock level and edge strobes.
// Flips the level on each tick and marks the direction of the flip.
// Forces everything low while cleared, without emitting a strobe.
module spi_sclk_div_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic sck_o,
    output logic lead_o,
    output logic trail_o
);

    // Level flip and edge strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sck_o   <= 1'b0;
            lead_o  <= 1'b0;
            trail_o <= 1'b0;
        end else begin
            if (tick_i) sck_o <= ~sck_o;
            lead_o  <= tick_i && !sck_o;
            trail_o <= tick_i && sck_o;
        end
    end

    assert_lead_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |-> (sck_o && !$past(sck_o)));
    assert_trail_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o |-> (!sck_o && $past(sck_o)));
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_o && trail_o));

endmodule

// File: rtl/spi_sclk_div.sv
// Dual-law SPI serial clock divider (top).
// Runs the phase counter only while the engine is busy and restarts it at each
// transfer start. Assumes xfer_start is a single-cycle pulse.
module spi_sclk_div #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int REG_W = LIN_W + EXP_W + 1,
    localparam int EXP_MAX = (1 << EXP_W) - 1,
    localparam int CNT_W = (LIN_W > EXP_MAX) ? LIN_W : EXP_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             xfer_start,
    input  logic             xfer_busy,
    output logic             sck_o,
    output logic             sck_lead_o,
    output logic             sck_trail_o
);

    logic [CNT_W-1:0] tc;
    logic             clear;
    logic             tick;

    assign clear = !xfer_busy || xfer_start;

    spi_sclk_div_cfg #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .CNT_W (CNT_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .xfer_start (xfer_start),
        .tc_o       (tc)
    );

    spi_sclk_div_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .tc_i    (tc),
        .tick_o  (tick)
    );

    spi_sclk_div_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .tick_i  (tick),
        .sck_o   (sck_o),
        .lead_o  (sck_lead_o),
        .trail_o (sck_trail_o)
    );

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |=> (!sck_o && !sck_lead_o && !sck_trail_o));
    assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !sck_o);
    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !xfer_start && !tick) |=> $stable(sck_o));

endmodule

// File: tb/spi_sclk_div_tb.sv
module spi_sclk_div_tb;

    localparam int NV = 10;
    localparam int unsigned VEC_CFG [NV] = '{
        32'h1000, 32'h1001, 32'h1004, 32'h1063, 32'h10FF,
        32'h0000, 32'h0100, 32'h0300, 32'h0500, 32'h02AB
    };
    localparam int unsigned VEC_H [NV] = '{
        1, 2, 5, 100, 256,
        1, 2, 8, 32, 4
    };
    localparam string VEC_REQ [NV] = '{
        "R4", "R2", "R2", "R2", "R2",
        "R3", "R3", "R3", "R3", "R1"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_wdata = '0;
    logic        xfer_start = 1'b0;
    logic        xfer_busy = 1'b0;
    logic        sck_o, sck_lead_o, sck_trail_o;

    int n_checks = 0;
    int n_fail = 0;
    int n_cyc = 0;

    always #10 clk = ~clk;

    spi_sclk_div u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .xfer_start  (xfer_start),
        .xfer_busy   (xfer_busy),
        .sck_o       (sck_o),
        .sck_lead_o  (sck_lead_o),
        .sck_trail_o (sck_trail_o)
    );

    always @(posedge clk) begin
        n_cyc <= n_cyc + 1;
        if (n_cyc > 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 190000", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic cmp(input logic [2:0] act, input logic [2:0] exp, input string req, input int j);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: {sck,lead,trail} actual %b expected %b", req, j, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [12:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_xfer();
        xfer_start = 1'b1;
        xfer_busy = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    // Checks cycles j_from..j_to after the start edge against half-period h.
    task automatic run_check(input int h, input int j_from, input int j_to, input string req);
        for (int j = j_from; j <= j_to; j++) begin
            int tg;
            logic [2:0] e;
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
            tg = j / h;
            e[2] = tg[0];
            e[1] = (j % h == 0) && tg[0];
            e[0] = (j % h == 0) && !tg[0];
            cmp({sck_o, sck_lead_o, sck_trail_o}, e, req, j);
        end
    endtask

    task automatic idle_check(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            cmp({sck_o, sck_lead_o, sck_trail_o}, 3'b000, req, k);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: outputs low out of reset
        cmp({sck_o, sck_lead_o, sck_trail_o}, 3'b000, "R9", 0);

        // Table walk: R1 R2 R3 R4 R5 R6 per vector
        for (int v = 0; v < NV; v++) begin
            int len;
            set_cfg(VEC_CFG[v][12:0]);
            start_xfer();
            len = (4 * VEC_H[v] + 2 < 8) ? 8 : 4 * VEC_H[v] + 2;
            run_check(VEC_H[v], 1, len, VEC_REQ[v]);
            xfer_busy = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end

        // R3: largest exponent, first rise exactly 32768 cycles after start (R5)
        set_cfg(13'h0F00);
        start_xfer();
        run_check(32768, 1, 32770, "R3");
        xfer_busy = 1'b0;

        // R7: idle with writes, nothing toggles
        set_cfg(13'h1000);
        idle_check(12, "R7");

        // R8: write during a transfer, rate unchanged until next start
        set_cfg(13'h1001);
        start_xfer();
        run_check(2, 1, 3, "R8");
        cfg_we = 1'b1;
        cfg_wdata = 13'h1004;
        run_check(2, 4, 10, "R8");

        // R10: busy dropped with sck high (j=10 high), returns low with no trail
        xfer_busy = 1'b0;
        idle_check(3, "R10");

        // R8/R5: next start uses the new rate with a full first half-period
        start_xfer();
        run_check(5, 1, 22, "R8");
        xfer_busy = 1'b0;

        // R1: law bit clear ignores the linear field
        set_cfg(13'h00FF);
        start_xfer();
        run_check(1, 1, 6, "R1");
        xfer_busy = 1'b0;
        @(posedge clk);
        @(negedge clk);

        // R9: reset mid-transfer returns outputs low
        set_cfg(13'h1002);
        start_xfer();
        run_check(3, 1, 4, "R5");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmp({sck_o, sck_lead_o, sck_trail_o}, 3'b000, "R9", 0);
        rst_n = 1'b1;
        xfer_busy = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule